// File: doc/BRIEF.md
# Memory-to-Memory Byte Copy and Fill Engine

This engine moves a block of bytes from one memory region to another over a single synchronous memory port. Two address pointers are used. The source pointer, always taken from channel 0, names the byte to fetch. The destination pointer, always taken from channel 1, names where that byte lands. Every byte passes through an internal staging register. The engine spends one bus cycle reading the source byte into that register and a later bus cycle writing it out. The staging register stays readable on a port after the run, so software can see the last byte moved.

A command byte sets the behaviour and is sampled when a start request is accepted. One bit enables the memory-to-memory operation. A second bit freezes the source pointer, which turns the copy into a fill: one source byte is replicated across the whole destination region. A third bit disables the engine. A fourth bit asks for compressed timing, which this operation does not support, so a start is refused while that bit is set.

The run length comes from the destination channel's count. The run ends after the write that moves the count from zero to all ones. An external end-of-process input can cut the run short.

Top module: `dma_m2m_engine`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `mem_re` and `mem_we` are low, and `src_cur`, `dst_cur`, `cnt_cur` and `temp_out` are zero.
- R2: A `start` pulse while idle is accepted only if `cmd` bit 0 (memory-to-memory enable) is 1, `cmd` bit 2 (disable) is 0 and `cmd` bit 3 (compressed timing) is 0. Otherwise it is ignored: `busy` stays low, no strobe is issued, and the current registers keep their values.
- R3: An accepted start loads `src_cur` from `src_base`, `dst_cur` from `dst_base` and `cnt_cur` from `count_base`. Each byte then takes three cycles in this order:
  - a read cycle, with `mem_re`=1 and `mem_addr`=`src_cur`;
  - a capture cycle, with no strobe;
  - a write cycle, with `mem_we`=1, `mem_addr`=`dst_cur` and `mem_wdata` equal to the byte read.
- R4: After each write cycle, `dst_cur` has advanced by one. `src_cur` has also advanced by one, unless `cmd` bit 1 (source hold) was set at start, in which case it does not change and the same byte fills the destination.
- R5: `cnt_cur` decreases by one after each write. The run ends after the write made while `cnt_cur` was zero, so a count of N moves N+1 bytes.
- R6: If `eop` is high in any cycle of a run, the run ends after the write of the byte in progress.
- R7: `temp_out` holds the byte captured in the most recent capture cycle and keeps it after the run ends.
- R8: `done` is high for exactly the one cycle after the final write. In that cycle `busy` is already low.
- R9: `mem_re` and `mem_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 8 | Command byte: bit0 enable, bit1 source hold, bit2 disable, bit3 compressed timing |
| src_base | input | AW | Starting source address (channel 0) |
| dst_base | input | AW | Starting destination address (channel 1) |
| count_base | input | CW | Byte count minus one (channel 1) |
| start | input | 1 | Start request, sampled while idle |
| eop | input | 1 | External end-of-process request |
| mem_addr | output | AW | Memory address |
| mem_re | output | 1 | Memory read strobe; data returns the next cycle |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data from memory |
| src_cur | output | AW | Current source address |
| dst_cur | output | AW | Current destination address |
| cnt_cur | output | CW | Current remaining count |
| temp_out | output | DW | Staging register contents |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
Suppose the phase sequencer gets out of step. The strobes then leave the read–capture–write rhythm within one cycle, so a write shows up without a read two cycles earlier. A wrong pointer or count shows up on `src_cur`, `dst_cur` or `cnt_cur` at the first write-cycle edge after the fault. A staging fault shows up on `mem_wdata` in the next write cycle, and later as corrupted destination memory. An end-of-run error, whether from a count-wrap mistake or a lost `eop`, shows up as one write too many or too few, and as a misplaced `done` pulse.

// File: rtl/dma_m2m_pkg.sv
package dma_m2m_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_CAPT  = 2'd2,
    PH_WRITE = 2'd3
  } phase_t;

  localparam int CMD_W        = 8;
  localparam int CMD_ENA_BIT  = 0;
  localparam int CMD_HOLD_BIT = 1;
  localparam int CMD_OFF_BIT  = 2;
  localparam int CMD_FAST_BIT = 3;
endpackage

// File: rtl/dma_m2m_ptr.sv
module dma_m2m_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step,
  output logic [AW-1:0] cur
);
  always_ff @(posedge clk) begin
    if (rst)       cur <= '0;
    else if (load) cur <= base;
    else if (step) cur <= cur + AW'(1);
  end
endmodule

// File: rtl/dma_m2m_stage.sv
module dma_m2m_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout
);
  always_ff @(posedge clk) begin
    if (rst)          dout <= '0;
    else if (capture) dout <= din;
  end
endmodule

// File: rtl/dma_m2m_seq.sv
module dma_m2m_seq
  import dma_m2m_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CMD_W-1:0] cmd,
  input  logic             start,
  input  logic             eop,
  input  logic [CW-1:0]    count_base,
  output phase_t           phase,
  output logic             load,
  output logic             src_step,
  output logic             dst_step,
  output logic             capture,
  output logic [CW-1:0]    cnt,
  output logic             done
);
  logic hold_q;
  logic eop_pend;
  logic last;

  assign load     = (phase == PH_IDLE) && start && cmd[CMD_ENA_BIT]
                    && !cmd[CMD_OFF_BIT] && !cmd[CMD_FAST_BIT];
  assign dst_step = (phase == PH_WRITE);
  assign src_step = (phase == PH_WRITE) && !hold_q;
  assign capture  = (phase == PH_CAPT);
  assign last     = (cnt == '0) || eop_pend || eop;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      hold_q   <= 1'b0;
      eop_pend <= 1'b0;
      cnt      <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (phase != PH_IDLE && eop) eop_pend <= 1'b1;
      case (phase)
        PH_IDLE: if (load) begin
          phase    <= PH_READ;
          hold_q   <= cmd[CMD_HOLD_BIT];
          cnt      <= count_base;
          eop_pend <= 1'b0;
        end
        PH_READ: phase <= PH_CAPT;
        PH_CAPT: phase <= PH_WRITE;
        PH_WRITE: begin
          cnt <= cnt - CW'(1);
          if (last) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            phase <= PH_READ;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma_m2m_engine.sv
module dma_m2m_engine
  import dma_m2m_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    cmd,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] dst_base,
  input  logic [CW-1:0] count_base,
  input  logic          start,
  input  logic          eop,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] src_cur,
  output logic [AW-1:0] dst_cur,
  output logic [CW-1:0] cnt_cur,
  output logic [DW-1:0] temp_out,
  output logic          busy,
  output logic          done
);
  localparam int NCH = 2;

  phase_t    phase;
  logic      load, src_step, dst_step, capture;
  logic [NCH-1:0]         ch_step;
  logic [NCH-1:0][AW-1:0] ch_base;
  logic [NCH-1:0][AW-1:0] ch_cur;

  dma_m2m_seq #(.CW(CW)) u_seq (
    .clk(clk), .rst(rst), .cmd(cmd), .start(start), .eop(eop),
    .count_base(count_base), .phase(phase), .load(load),
    .src_step(src_step), .dst_step(dst_step), .capture(capture),
    .cnt(cnt_cur), .done(done)
  );

  assign ch_step = {dst_step, src_step};
  assign ch_base = {dst_base, src_base};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_m2m_ptr #(.AW(AW)) u_ptr (
      .clk(clk), .rst(rst), .load(load), .base(ch_base[g]),
      .step(ch_step[g]), .cur(ch_cur[g])
    );
  end

  dma_m2m_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst(rst), .capture(capture), .din(mem_rdata), .dout(temp_out)
  );

  assign src_cur   = ch_cur[0];
  assign dst_cur   = ch_cur[1];
  assign mem_re    = (phase == PH_READ);
  assign mem_we    = (phase == PH_WRITE);
  assign mem_addr  = mem_we ? dst_cur : src_cur;
  assign mem_wdata = temp_out;
  assign busy      = (phase != PH_IDLE);
endmodule

// File: rtl/dma_m2m_engine_chk.sv
module dma_m2m_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [7:0]    cmd,
  input logic          mem_re,
  input logic          mem_we,
  input logic [AW-1:0] src_cur,
  input logic [AW-1:0] dst_cur,
  input logic [CW-1:0] cnt_cur,
  input logic          busy,
  input logic          done
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      assert_reset_idle_R1: assert (!busy && !done && !mem_re && !mem_we
                                    && src_cur == '0 && dst_cur == '0 && cnt_cur == '0);
    end
  end

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(cmd[0] && !cmd[2] && !cmd[3])) |=> !busy);

  assert_byte_rhythm_R3: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> (!mem_re && !mem_we) ##1 mem_we);

  assert_dst_step_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> dst_cur == $past(dst_cur) + AW'(1));

  assert_src_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && !mem_we) |=> $stable(src_cur));

  assert_cnt_step_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> cnt_cur == $past(cnt_cur) - CW'(1));

  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(mem_we)));

  assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(mem_re && mem_we));
endmodule

bind dma_m2m_engine dma_m2m_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .cmd(cmd), .mem_re(mem_re), .mem_we(mem_we),
  .src_cur(src_cur), .dst_cur(dst_cur), .cnt_cur(cnt_cur),
  .busy(busy), .done(done)
);

// File: tb/dma_m2m_engine_bench.sv
module dma_m2m_engine_bench;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    cmd = 8'h00;
  logic [AW-1:0] src_base = '0, dst_base = '0;
  logic [CW-1:0] count_base = '0;
  logic          start = 1'b0, eop = 1'b0;
  logic [AW-1:0] mem_addr, src_cur, dst_cur;
  logic          mem_re, mem_we, busy, done;
  logic [DW-1:0] mem_wdata, temp_out;
  logic [DW-1:0] mem_rdata = '0;
  logic [CW-1:0] cnt_cur;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  dma_m2m_engine #(.AW(AW), .DW(DW), .CW(CW)) u_dma_m2m_engine (
    .clk(clk), .rst(rst), .cmd(cmd), .src_base(src_base), .dst_base(dst_base),
    .count_base(count_base), .start(start), .eop(eop), .mem_addr(mem_addr),
    .mem_re(mem_re), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .src_cur(src_cur), .dst_cur(dst_cur), .cnt_cur(cnt_cur), .temp_out(temp_out),
    .busy(busy), .done(done)
  );

  // memory seen by the design, and the model's own copy
  logic [DW-1:0] mem [256];
  logic [DW-1:0] ref_mem [256];

  always @(posedge clk) begin
    if (mem_re) mem_rdata <= mem[mem_addr];
    if (mem_we) mem[mem_addr] <= mem_wdata;
  end

  // behavioural reference: phase 0 idle, 1 read, 2 capture, 3 write
  int            m_ph = 0;
  logic [AW-1:0] m_src = '0, m_dst = '0;
  logic [CW-1:0] m_cnt = '0;
  logic [DW-1:0] m_temp = '0;
  bit            m_hold = 0, m_pend = 0, m_done = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph <= 0; m_src <= '0; m_dst <= '0; m_cnt <= '0;
      m_temp <= '0; m_hold <= 0; m_pend <= 0; m_done <= 0;
    end else begin
      m_done <= 0;
      if (m_ph != 0 && eop) m_pend <= 1;
      case (m_ph)
        0: if (start && cmd[0] && !cmd[2] && !cmd[3]) begin
          m_ph <= 1; m_src <= src_base; m_dst <= dst_base;
          m_cnt <= count_base; m_hold <= cmd[1]; m_pend <= 0;
        end
        1: m_ph <= 2;
        2: begin m_temp <= ref_mem[m_src]; m_ph <= 3; end
        default: begin
          ref_mem[m_dst] <= m_temp;
          m_dst <= m_dst + 1'b1;
          if (!m_hold) m_src <= m_src + 1'b1;
          m_cnt <= m_cnt - 1'b1;
          if (m_cnt == 0 || m_pend || eop) begin m_ph <= 0; m_done <= 1; end
          else m_ph <= 1;
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      chk(mem_re == (m_ph == 1) && mem_we == (m_ph == 3), "R3 strobes",
          {mem_re, mem_we}, {m_ph == 1, m_ph == 3});
      chk(!(mem_re && mem_we), "R9 strobe exclusion", {mem_re, mem_we}, 0);
      if (m_ph == 1) chk(mem_addr == m_src, "R3 read addr", mem_addr, m_src);
      if (m_ph == 3) begin
        chk(mem_addr == m_dst, "R3 write addr", mem_addr, m_dst);
        chk(mem_wdata == m_temp, "R3 write data", mem_wdata, m_temp);
      end
      chk(src_cur == m_src && dst_cur == m_dst, "R4 pointers",
          {src_cur, dst_cur}, {m_src, m_dst});
      chk(cnt_cur == m_cnt, "R5 count", cnt_cur, m_cnt);
      chk(temp_out == m_temp, "R7 staging", temp_out, m_temp);
      chk(busy == (m_ph != 0) && done == m_done, "R8 busy/done",
          {busy, done}, {m_ph != 0, m_done});
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic run(input logic [7:0] c, input int s, input int d, input int n);
    @(negedge clk);
    cmd = c; src_base = AW'(s); dst_base = AW'(d); count_base = CW'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = DW'(i * 7 + 3);
      ref_mem[i] = DW'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !mem_re && !mem_we, "R1 idle strobes",
        {busy, done, mem_re, mem_we}, 0);
    chk(src_cur == 0 && dst_cur == 0 && cnt_cur == 0 && temp_out == 0,
        "R1 registers zero", {src_cur, dst_cur, cnt_cur, temp_out}, 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5: plain copy of 4 bytes
    run(8'h01, 8'h10, 8'h40, 3);
    wait_idle();
    for (int i = 0; i < 4; i++)
      chk(mem[8'h40 + i] == DW'((8'h10 + i) * 7 + 3), "R5 copied byte",
          mem[8'h40 + i], DW'((8'h10 + i) * 7 + 3));
    chk(mem[8'h44] == DW'(8'h44 * 7 + 3), "R5 no extra write",
        mem[8'h44], DW'(8'h44 * 7 + 3));
    chk(temp_out == DW'(8'h13 * 7 + 3), "R7 last byte kept",
        temp_out, DW'(8'h13 * 7 + 3));

    // R4: fill with frozen source
    run(8'h03, 8'h20, 8'h80, 5);
    wait_idle();
    for (int i = 0; i < 6; i++)
      chk(mem[8'h80 + i] == DW'(8'h20 * 7 + 3), "R4 fill byte",
          mem[8'h80 + i], DW'(8'h20 * 7 + 3));
    chk(src_cur == 8'h20, "R4 source held", src_cur, 8'h20);

    // R2: refused starts (disable, no enable, compressed timing)
    run(8'h05, 8'h30, 8'h90, 2);
    chk(!busy && dst_cur == 8'h86, "R2 disabled ignored", {busy, dst_cur}, 8'h86);
    run(8'h00, 8'h30, 8'h90, 2);
    chk(!busy && src_cur == 8'h20, "R2 not enabled ignored", {busy, src_cur}, 8'h20);
    run(8'h09, 8'h30, 8'h90, 2);
    chk(!busy && cnt_cur == CW'(-1), "R2 fast timing ignored", {busy, cnt_cur}, CW'(-1));

    // R6: eop during second byte
    run(8'h01, 8'h50, 8'hA0, 20);
    repeat (4) @(negedge clk);
    eop = 1'b1;
    @(negedge clk);
    eop = 1'b0;
    wait_idle();
    chk(dst_cur == 8'hA2, "R6 stopped after byte two", dst_cur, 8'hA2);
    chk(mem[8'hA2] == DW'(8'hA2 * 7 + 3), "R6 no third write",
        mem[8'hA2], DW'(8'hA2 * 7 + 3));

    // R5: count of zero moves one byte, with destination wrap
    run(8'h01, 8'h60, 8'hFF, 0);
    wait_idle();
    chk(mem[8'hFF] == DW'(8'h60 * 7 + 3) && dst_cur == 8'h00, "R5 single byte",
        {mem[8'hFF], dst_cur}, {DW'(8'h60 * 7 + 3), 8'h00});

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule